// File: doc/BRIEF.md
# Fetch-Stage Branch Target Table

This block sits beside the instruction fetch unit. In the same cycle that a fetch address is presented, it reports whether that address is a known taken branch. It also supplies the address to fetch next. On a hit, the next address is the target the table has stored. On a miss, it is the sequential address, four bytes on. The pipeline therefore learns where to go before decode has recognised the instruction as a branch or computed its target.

The table is filled and pruned from a single update port, driven by the stage that resolves branches. That stage reports the branch address, whether the branch was taken and where it went. The table keeps entries only for branches whose most recent outcome was taken:

- A taken branch that is absent is installed.
- A resident branch that falls through is removed.
- A resident branch whose target has moved has its target rewritten.
- A not-taken branch that is absent costs nothing and changes nothing.

The table is direct-mapped with 2^IDX_W entries. Each entry holds a valid flag, a tag and a full-width target.

Top module: `fetch_target_table`

## Requirements
- R1: A synchronous active-high reset empties the table. In the first cycle after reset, every fetch address misses and `pred_next_pc` equals `fetch_pc + 4`.
- R2: On a miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4` in the same cycle.
- R3: `pred_hit` is 1 when the entry selected by `fetch_pc[IDX_W+1:2]` is valid and its tag equals `fetch_pc[ADDR_W-1:IDX_W+2]`. In that case `pred_next_pc` carries the stored target, and both are combinational in the cycle of `fetch_pc`.
- R4: An update with `upd_taken`=1 for an address that misses installs that address with `upd_target`. A lookup of that address hits from the cycle after the update edge.
- R5: An update with `upd_taken`=0 for a resident address invalidates its entry. Later lookups of it miss.
- R6: An update with `upd_taken`=0 for an address that is not resident changes nothing. This holds even when another branch occupies the same index: that branch still hits with its old target.
- R7: An update with `upd_taken`=1 for a resident address whose stored target differs from `upd_target` replaces the target. The entry stays valid.
- R8: A taken update for an address that shares an index with a different resident branch evicts that branch. The old branch then misses and the new one hits.
- R9: When an update and a lookup hit the same index in one cycle, the lookup sees the contents from before the update. The new contents appear only after the clock edge.
- R10: Address bits [1:0] take no part in the lookup. Two addresses that differ only there give the same result.
- R11: While `upd_valid` is 0, the other update inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all valid flags |
| fetch_pc | input | ADDR_W | Address of the instruction being fetched |
| pred_hit | output | 1 | Fetch address is a resident taken branch |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch report is present this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
Lookup results are combinational and are due in the same cycle as `fetch_pc`. The bench therefore changes `fetch_pc` on the falling edge and compares the outputs one nanosecond later, well before the next rising edge. An update takes effect at the first rising edge at which `upd_valid` is high. Each scenario drives the report on a falling edge, removes it on the next falling edge, and only then looks up the affected addresses. For R9, the lookup is compared while the report is still applied, before its edge, and again after that edge.

// File: rtl/ftt_pkg.sv
package ftt_pkg;
  typedef enum logic [1:0] {
    UPD_NONE     = 2'd0,
    UPD_FILL     = 2'd1,
    UPD_RETARGET = 2'd2,
    UPD_DROP     = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/ftt_field_split.sv
module ftt_field_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-3:0] word_addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  // word address drops the two byte-offset bits; low part selects the slot
  assign idx = word_addr[IDX_W-1:0];
  assign tag = word_addr[ADDR_W-3:IDX_W];
endmodule

// File: rtl/ftt_table.sv
module ftt_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic              rd_a_vld,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [ADDR_W-1:0] rd_a_tgt,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              rd_b_vld,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [ADDR_W-1:0] rd_b_tgt,
  input  logic              wr_en,
  input  logic              drop_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt
);
  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [ADDR_W-1:0] tgt_mem [DEPTH];

  // valid flags live in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end else if (drop_en) begin
      vld_q[wr_idx] <= 1'b0;
    end
  end

  // payload arrays carry no reset: a plain write-enabled memory
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign rd_a_vld = vld_q[rd_a_idx];
  assign rd_a_tag = tag_mem[rd_a_idx];
  assign rd_a_tgt = tgt_mem[rd_a_idx];
  assign rd_b_vld = vld_q[rd_b_idx];
  assign rd_b_tag = tag_mem[rd_b_idx];
  assign rd_b_tgt = tgt_mem[rd_b_idx];
endmodule

// File: rtl/ftt_update_ctl.sv
module ftt_update_ctl #(
  parameter int ADDR_W = 32
) (
  input  logic              upd_valid,
  input  logic              upd_taken,
  input  logic              res_hit,
  input  logic [ADDR_W-1:0] res_tgt,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              wr_en,
  output logic              drop_en
);
  import ftt_pkg::*;

  upd_kind_e kind;

  always_comb begin
    kind = UPD_NONE;
    if (upd_valid) begin
      if (upd_taken && !res_hit) begin
        kind = UPD_FILL;
      end else if (upd_taken && (res_tgt != upd_target)) begin
        kind = UPD_RETARGET;
      end else if (!upd_taken && res_hit) begin
        kind = UPD_DROP;
      end
    end
  end

  assign wr_en   = (kind == UPD_FILL) || (kind == UPD_RETARGET);
  assign drop_en = (kind == UPD_DROP);
endmodule

// File: rtl/fetch_target_table.sv
module fetch_target_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic              f_vld, u_vld;
  logic [TAG_W-1:0]  f_stag, u_stag;
  logic [ADDR_W-1:0] f_stgt, u_stgt;
  logic              u_hit;
  logic              wr_en, drop_en;

  ftt_field_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fetch_split_i (
    .word_addr (fetch_pc[ADDR_W-1:2]),
    .idx       (f_idx),
    .tag       (f_tag)
  );

  ftt_field_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) upd_split_i (
    .word_addr (upd_pc[ADDR_W-1:2]),
    .idx       (u_idx),
    .tag       (u_tag)
  );

  ftt_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) table_i (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (f_idx),
    .rd_a_vld (f_vld),
    .rd_a_tag (f_stag),
    .rd_a_tgt (f_stgt),
    .rd_b_idx (u_idx),
    .rd_b_vld (u_vld),
    .rd_b_tag (u_stag),
    .rd_b_tgt (u_stgt),
    .wr_en    (wr_en),
    .drop_en  (drop_en),
    .wr_idx   (u_idx),
    .wr_tag   (u_tag),
    .wr_tgt   (upd_target)
  );

  assign u_hit = u_vld && (u_stag == u_tag);

  ftt_update_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .res_hit    (u_hit),
    .res_tgt    (u_stgt),
    .upd_target (upd_target),
    .wr_en      (wr_en),
    .drop_en    (drop_en)
  );

  assign pred_hit     = f_vld && (f_stag == f_tag);
  assign pred_next_pc = pred_hit ? f_stgt : (fetch_pc + STEP);
endmodule

// File: rtl/ftt_checker.sv
module ftt_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target
);
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_hit); // R1

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_next_pc == fetch_pc + ADDR_W'(4))); // R2

  AST_TAKEN_RESIDENT: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && upd_valid && upd_taken) && (fetch_pc == $past(upd_pc)))
      |-> (pred_hit && pred_next_pc == $past(upd_target))); // R4

  AST_FALLTHRU_GONE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && upd_valid && !upd_taken) && (fetch_pc == $past(upd_pc)))
      |-> !pred_hit); // R5

  AST_HIT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(pred_hit)); // R3
endmodule

bind fetch_target_table ftt_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/fetch_target_table_tb_top.sv
module fetch_target_table_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] pred_next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_target_table #(.ADDR_W(32), .IDX_W(4)) dut_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_next_pc(pred_next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  task automatic look(input string req, input logic [31:0] pc,
                      input logic exp_hit, input logic [31:0] exp_next);
    fetch_pc = pc;
    #1;
    total++;
    if (pred_hit !== exp_hit || pred_next_pc !== exp_next) begin
      bad++;
      $display("FAIL %s pc=%h hit=%b next=%h expected hit=%b next=%h",
               req, pc, pred_hit, pred_next_pc, exp_hit, exp_next);
    end
  endtask

  task automatic report(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    report(32'h0000_0200, 1'b1, 32'h0000_8000);
    look("R4", 32'h0000_0200, 1'b1, 32'h0000_8000);
    do_reset();
    look("R1", 32'h0000_0200, 1'b0, 32'h0000_0204);
    look("R1", 32'h0000_0000, 1'b0, 32'h0000_0004);
  endtask

  task automatic t_miss();
    look("R2", 32'h0000_1234, 1'b0, 32'h0000_1238);
    look("R2", 32'hFFFF_FFFC, 1'b0, 32'h0000_0000);
  endtask

  task automatic t_alloc();
    report(32'h0000_0104, 1'b1, 32'h0000_4000);
    look("R4", 32'h0000_0104, 1'b1, 32'h0000_4000);
    look("R3", 32'h0000_0108, 1'b0, 32'h0000_010C);
    look("R3", 32'h0001_0104, 1'b0, 32'h0001_0108);
  endtask

  task automatic t_lowbits();
    look("R10", 32'h0000_0107, 1'b1, 32'h0000_4000);
  endtask

  task automatic t_retarget();
    report(32'h0000_0104, 1'b1, 32'h0000_5000);
    look("R7", 32'h0000_0104, 1'b1, 32'h0000_5000);
  endtask

  task automatic t_idle();
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 32'h0000_0104; upd_taken = 1'b0; upd_target = 32'h0;
    @(negedge clk);
    look("R11", 32'h0000_0104, 1'b1, 32'h0000_5000);
  endtask

  task automatic t_nt_absent();
    report(32'h0000_0144, 1'b0, 32'h0);
    look("R6", 32'h0000_0104, 1'b1, 32'h0000_5000);
    look("R6", 32'h0000_0144, 1'b0, 32'h0000_0148);
  endtask

  task automatic t_drop();
    report(32'h0000_0104, 1'b0, 32'h0);
    look("R5", 32'h0000_0104, 1'b0, 32'h0000_0108);
  endtask

  task automatic t_alias();
    report(32'h0000_0100, 1'b1, 32'h0000_6000);
    report(32'h0000_0140, 1'b1, 32'h0000_7000);
    look("R8", 32'h0000_0140, 1'b1, 32'h0000_7000);
    look("R8", 32'h0000_0100, 1'b0, 32'h0000_0104);
  endtask

  task automatic t_same_cycle();
    report(32'h0000_0300, 1'b1, 32'h0000_1000);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_0300; upd_taken = 1'b1; upd_target = 32'h0000_2000;
    look("R9", 32'h0000_0300, 1'b1, 32'h0000_1000);
    @(negedge clk);
    upd_valid = 1'b0;
    look("R9", 32'h0000_0300, 1'b1, 32'h0000_2000);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_0310; upd_taken = 1'b1; upd_target = 32'h0000_3000;
    look("R9", 32'h0000_0310, 1'b0, 32'h0000_0314);
    @(negedge clk);
    upd_valid = 1'b0;
    look("R9", 32'h0000_0310, 1'b1, 32'h0000_3000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_miss();
    t_alloc();
    t_lowbits();
    t_retarget();
    t_idle();
    t_nt_absent();
    t_drop();
    t_alias();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule